// File: doc/BRIEF.md
# Flavor-Selectable Eight-Line GPIO Bank

This block is an eight-line general-purpose I/O bank reached through a byte-wide register port: an address, a write strobe with write data, and read data that follows the address in the same cycle. A synthesis-time parameter builds it as one of three flavors. Bidirectional lines each have a direction bit. Input-only lines can never be driven. Output-only lines are always driven. Each flavor has its own register layout.

Host software changes a single line by reading a whole register byte, changing one bit and writing the byte back. For that reason every writable register reads back exactly the value last written to it. Pad inputs pass through a two-stage synchroniser before software can see them. The register port has no flow control: every access completes in the cycle it is presented, so there is no valid/ready exchange and no back-pressure. The pad side is plain level signalling.

Top module: `gpio_flex_bank`

## Requirements
- R1: The bank has 8 lines, with bit n of every register belonging to line n. In the bidirectional flavor the direction register is at offset 0, the output register at offset 1 and the input register at offset 2.
- R2: In the bidirectional flavor a direction bit of 1 drives its line (pad_oe bit 1) and a 0 makes it an input. pad_oe equals the direction register from the cycle after the write.
- R3: pad_out equals the output register from the cycle after a write to that register, in the flavors that have one.
- R4: A change on pad_in shows in the input register readback after exactly two rising clock edges. After one edge the old value still reads back.
- R5: After reset the direction and output registers read 0x00, pad_out is 0x00 and, in the bidirectional flavor, pad_oe is 0x00, so every line is an input.
- R6: Every writable register reads back the last byte written to it.
- R7: Writes to the input register or to unmapped offsets change no register and no pad output. Reads of unmapped offsets return 0x00.
- R8: In the input-only flavor the input register is at offset 0, pad_oe is always 0x00, and writes to any offset have no effect.
- R9: In the output-only flavor the output register is at offset 0, reading it returns the latched output byte, pad_oe is always 0xFF, and every other offset reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Register offset |
| reg_we | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | NUM_LINES | Write data |
| reg_rdata | output | NUM_LINES | Read data for reg_addr, same cycle |
| pad_in | input | NUM_LINES | Asynchronous pad inputs |
| pad_out | output | NUM_LINES | Pad output values |
| pad_oe | output | NUM_LINES | Pad output enables, 1 = driven |

## Verification
The bench builds three instances side by side on one shared register port and pad input: FLAVOR set to the bidirectional, the input-only and the output-only value, each with 8 lines and a 2-bit address. Because one write reaches all three instances, the same stimulus tests three things at once. It checks a mapped register in one flavor, shows that the offset is ignored in another, and shows that the value reads back as zero where the offset is unmapped. Using the full 2-bit address also reaches the one offset that is unmapped in every flavor.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  typedef enum logic [1:0] {
    FLAVOR_BIDIR    = 2'd0,
    FLAVOR_IN_ONLY  = 2'd1,
    FLAVOR_OUT_ONLY = 2'd2
  } flavor_e;

  typedef enum logic [1:0] {
    RSEL_NONE = 2'd0,
    RSEL_DIR  = 2'd1,
    RSEL_OUT  = 2'd2,
    RSEL_IN   = 2'd3
  } rsel_e;

  // bidirectional layout
  localparam int BI_OFF_DIR = 0;
  localparam int BI_OFF_OUT = 1;
  localparam int BI_OFF_IN  = 2;
  // single-register layouts
  localparam int SOLO_OFF   = 0;

  function automatic int mapped_count(flavor_e f);
    return (f == FLAVOR_BIDIR) ? 3 : 1;
  endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_bank_decode.sv
module gpio_bank_decode
  import gpio_bank_pkg::*;
#(
  parameter flavor_e FLAVOR = FLAVOR_BIDIR,
  parameter int      ADDR_W = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              wr_dir,
  output logic              wr_out,
  output rsel_e             rsel
);
  always_comb begin
    rsel = RSEL_NONE;
    unique case (FLAVOR)
      FLAVOR_BIDIR: begin
        if (int'(addr) == BI_OFF_DIR)      rsel = RSEL_DIR;
        else if (int'(addr) == BI_OFF_OUT) rsel = RSEL_OUT;
        else if (int'(addr) == BI_OFF_IN)  rsel = RSEL_IN;
      end
      FLAVOR_IN_ONLY:  if (int'(addr) == SOLO_OFF) rsel = RSEL_IN;
      FLAVOR_OUT_ONLY: if (int'(addr) == SOLO_OFF) rsel = RSEL_OUT;
      default: rsel = RSEL_NONE;
    endcase
  end

  // the input register is read-only, so only DIR and OUT take writes
  assign wr_dir = we && (rsel == RSEL_DIR);
  assign wr_out = we && (rsel == RSEL_OUT);
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter flavor_e FLAVOR = FLAVOR_BIDIR,
  parameter int      WIDTH  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_dir,
  input  logic             wr_out,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] out_q
);
  if (FLAVOR == FLAVOR_BIDIR) begin : g_dir_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      dir_q <= '0;
      else if (wr_dir) dir_q <= wdata;
    end
  end else if (FLAVOR == FLAVOR_OUT_ONLY) begin : g_dir_out
    assign dir_q = '1;
  end else begin : g_dir_in
    assign dir_q = '0;
  end

  if (FLAVOR != FLAVOR_IN_ONLY) begin : g_out_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      out_q <= '0;
      else if (wr_out) out_q <= wdata;
    end
  end else begin : g_out_none
    assign out_q = '0;
  end
endmodule

// File: rtl/gpio_bank_rdmux.sv
module gpio_bank_rdmux
  import gpio_bank_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  rsel_e            rsel,
  input  logic [WIDTH-1:0] dir_q,
  input  logic [WIDTH-1:0] out_q,
  input  logic [WIDTH-1:0] in_sync,
  output logic [WIDTH-1:0] rdata
);
  always_comb begin
    unique case (rsel)
      RSEL_DIR: rdata = dir_q;
      RSEL_OUT: rdata = out_q;
      RSEL_IN:  rdata = in_sync;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_flex_bank.sv
module gpio_flex_bank
  import gpio_bank_pkg::*;
#(
  parameter flavor_e FLAVOR    = FLAVOR_BIDIR,
  parameter int      NUM_LINES = 8,
  parameter int      ADDR_W    = 2,
  parameter int      SYNC_LEN  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [NUM_LINES-1:0] reg_wdata,
  output logic [NUM_LINES-1:0] reg_rdata,
  input  logic [NUM_LINES-1:0] pad_in,
  output logic [NUM_LINES-1:0] pad_out,
  output logic [NUM_LINES-1:0] pad_oe
);
  localparam int MAP_SIZE = mapped_count(FLAVOR);
  localparam int OUT_OFF  = (FLAVOR == FLAVOR_BIDIR) ? BI_OFF_OUT : SOLO_OFF;

  logic              wr_dir, wr_out;
  rsel_e             rsel;
  logic [NUM_LINES-1:0] dir_q, out_q, in_sync;

  gpio_bank_decode #(.FLAVOR(FLAVOR), .ADDR_W(ADDR_W)) u_decode (
    .addr(reg_addr), .we(reg_we), .wr_dir(wr_dir), .wr_out(wr_out), .rsel(rsel)
  );

  gpio_bank_regs #(.FLAVOR(FLAVOR), .WIDTH(NUM_LINES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_dir(wr_dir), .wr_out(wr_out),
    .wdata(reg_wdata), .dir_q(dir_q), .out_q(out_q)
  );

  if (FLAVOR != FLAVOR_OUT_ONLY) begin : g_sync
    gpio_bank_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_LEN)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(in_sync)
    );
  end else begin : g_nosync
    assign in_sync = '0;
  end

  gpio_bank_rdmux #(.WIDTH(NUM_LINES)) u_rdmux (
    .rsel(rsel), .dir_q(dir_q), .out_q(out_q), .in_sync(in_sync), .rdata(reg_rdata)
  );

  assign pad_out = out_q;
  assign pad_oe  = dir_q;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(reg_addr) >= MAP_SIZE) |-> (reg_rdata == '0)); // R7

  if (FLAVOR != FLAVOR_IN_ONLY) begin : g_out_chk
    AST_OUT_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && int'(reg_addr) == OUT_OFF) |=> (pad_out == $past(reg_wdata))); // R3
    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && int'(reg_addr) == OUT_OFF) |=> $stable(pad_out)); // R7
  end

  if (FLAVOR == FLAVOR_BIDIR) begin : g_dir_chk
    AST_OE_TAKES_DIR: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && int'(reg_addr) == BI_OFF_DIR) |=> (pad_oe == $past(reg_wdata))); // R2
    AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_we && int'(reg_addr) == BI_OFF_DIR) |=> $stable(pad_oe)); // R7
  end
endmodule

// File: tb/gpio_flex_bank_tb.sv
module gpio_flex_bank_tb_top;
  import gpio_bank_pkg::*;

  localparam int W = 8;
  localparam int A = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [A-1:0] reg_addr = '0;
  logic         reg_we = 1'b0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] pad_in = '0;

  logic [W-1:0] rd_bi, rd_in, rd_out;
  logic [W-1:0] po_bi, po_in, po_out;
  logic [W-1:0] oe_bi, oe_in, oe_out;

  always #4 clk = ~clk;  // 125 MHz

  gpio_flex_bank #(.FLAVOR(FLAVOR_BIDIR), .NUM_LINES(W), .ADDR_W(A)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd_bi), .pad_in(pad_in),
    .pad_out(po_bi), .pad_oe(oe_bi));
  gpio_flex_bank #(.FLAVOR(FLAVOR_IN_ONLY), .NUM_LINES(W), .ADDR_W(A)) dut_in_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd_in), .pad_in(pad_in),
    .pad_out(po_in), .pad_oe(oe_in));
  gpio_flex_bank #(.FLAVOR(FLAVOR_OUT_ONLY), .NUM_LINES(W), .ADDR_W(A)) dut_out_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(rd_out), .pad_in(pad_in),
    .pad_out(po_out), .pad_oe(oe_out));

  typedef enum int {
    S_RD_BI, S_RD_IN, S_RD_OUT, S_OE_BI, S_OE_IN, S_OE_OUT, S_PO_BI, S_PO_OUT
  } probe_e;
  typedef struct {
    probe_e       probe;
    logic [W-1:0] exp;
    string        req;
  } item_t;

  item_t expq[$];
  event  sample_ev;
  int    checks = 0;
  int    failures = 0;
  bit    done = 1'b0;

  function automatic logic [W-1:0] probe_val(probe_e p);
    case (p)
      S_RD_BI:  return rd_bi;
      S_RD_IN:  return rd_in;
      S_RD_OUT: return rd_out;
      S_OE_BI:  return oe_bi;
      S_OE_IN:  return oe_in;
      S_OE_OUT: return oe_out;
      S_PO_BI:  return po_bi;
      default:  return po_out;
    endcase
  endfunction

  // monitor: compares queued expectations once outputs have settled
  initial begin
    forever begin
      @(sample_ev);
      #1;
      while (expq.size() > 0) begin
        item_t it;
        logic [W-1:0] act;
        it = expq.pop_front();
        act = probe_val(it.probe);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s probe=%s actual=%02h expected=%02h",
                   it.req, it.probe.name(), act, it.exp);
        end
      end
    end
  end

  task automatic expect_v(probe_e p, logic [W-1:0] e, string r);
    item_t it;
    it.probe = p; it.exp = e; it.req = r;
    expq.push_back(it);
  endtask

  task automatic flush();
    -> sample_ev;
    #2;
  endtask

  task automatic wr(logic [A-1:0] a, logic [W-1:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic at_addr(logic [A-1:0] a);
    @(negedge clk);
    reg_addr = a;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5 reset state
    at_addr(2'd0);
    expect_v(S_RD_BI, 8'h00, "R5"); expect_v(S_OE_BI, 8'h00, "R5");
    expect_v(S_PO_BI, 8'h00, "R5"); expect_v(S_RD_OUT, 8'h00, "R5");
    expect_v(S_OE_OUT, 8'hFF, "R9"); expect_v(S_OE_IN, 8'h00, "R8");
    flush();
    at_addr(2'd1);
    expect_v(S_RD_BI, 8'h00, "R5");
    flush();

    // R1 R2 R6: direction at offset 0
    wr(2'd0, 8'hA5);
    at_addr(2'd0);
    expect_v(S_RD_BI, 8'hA5, "R6"); expect_v(S_OE_BI, 8'hA5, "R2");
    expect_v(S_RD_OUT, 8'hA5, "R9"); expect_v(S_PO_OUT, 8'hA5, "R9");
    expect_v(S_OE_IN, 8'h00, "R8");
    flush();

    // R1 R3: output at offset 1; unmapped in output-only flavor
    wr(2'd1, 8'h3C);
    at_addr(2'd1);
    expect_v(S_RD_BI, 8'h3C, "R1"); expect_v(S_PO_BI, 8'h3C, "R3");
    expect_v(S_PO_OUT, 8'hA5, "R9"); expect_v(S_RD_OUT, 8'h00, "R9");
    expect_v(S_RD_IN, 8'h00, "R8");
    flush();

    // R7: write to read-only input offset and to unmapped offset 3
    wr(2'd2, 8'hFF);
    wr(2'd3, 8'h77);
    at_addr(2'd3);
    expect_v(S_RD_BI, 8'h00, "R7"); expect_v(S_PO_BI, 8'h3C, "R7");
    expect_v(S_OE_BI, 8'hA5, "R7"); expect_v(S_RD_IN, 8'h00, "R7");
    flush();
    at_addr(2'd2);
    expect_v(S_RD_BI, 8'h00, "R7");
    flush();

    // R4: two-edge synchroniser
    @(negedge clk);
    pad_in = 8'h5A;
    reg_addr = 2'd2;
    @(negedge clk);
    expect_v(S_RD_BI, 8'h00, "R4");
    flush();
    @(negedge clk);
    expect_v(S_RD_BI, 8'h5A, "R4");
    flush();
    at_addr(2'd0);
    expect_v(S_RD_IN, 8'h5A, "R8");
    flush();

    // R8: write at offset 0 leaves input-only readback as pad value
    wr(2'd0, 8'h0F);
    at_addr(2'd0);
    expect_v(S_RD_IN, 8'h5A, "R8"); expect_v(S_OE_IN, 8'h00, "R8");
    expect_v(S_RD_BI, 8'h0F, "R6"); expect_v(S_OE_BI, 8'h0F, "R2");
    expect_v(S_RD_OUT, 8'h0F, "R9"); expect_v(S_OE_OUT, 8'hFF, "R9");
    flush();

    // R6 read-modify-write of one line
    wr(2'd1, 8'h3C | 8'h01);
    at_addr(2'd1);
    expect_v(S_RD_BI, 8'h3D, "R6"); expect_v(S_PO_BI, 8'h3D, "R3");
    flush();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule